// File: doc/BRIEF.md
# Shared-Dictionary Cache Block Compressor

This block packs a group of neighbouring cache blocks into one compact entry. Every block is cut into 32-bit chunks. The compressor keeps a single small dictionary of the distinct chunk values seen anywhere in the group, and it replaces each chunk with a short index into that dictionary. The encoding is built for the group as a whole, so a value repeated in several neighbours costs one dictionary slot. The entry that results fits a normal data array, and the tag layout does not change.

Chunks enter one per cycle through a valid/ready stream. The producer holds `in_valid`, `in_chunk` and `in_last` steady until a cycle where `in_ready` is high, and `in_last` marks the final chunk of the group. The encoded group then appears on a valid/ready result port, and the block keeps every output field stable while `out_ready` stays low. During that time `in_ready` is low, so the next group waits. When a group needs more distinct values than the dictionary can hold, or has too many chunks, the result is flagged as not fitting and its partial encoding is dropped.

The decoder is separate and has no state tied to the compressor. A caller supplies a dictionary and the index list of one block. The rebuilt block is returned on the next clock edge, with each chunk produced by a direct table lookup.

Top module: `sdc_compressor`

## Requirements
- R1: Out of reset, `in_ready` is 1, `out_valid` is 0 and `dec_vld` is 0.
- R2: On a fitting group, `out_dict_cnt` equals the number of distinct chunk values in the group. Slot i (bits 32i+31..32i of `out_dict`) holds the i-th distinct value in arrival order, and the unused slots read zero.
- R3: On a fitting group, the 3-bit field at bit offset 3*(16*b+p) of `out_idx` holds the dictionary slot of chunk p of block b. Chunks arrive block by block, with chunk 0 first.
- R4: On a fitting group, `out_nblk` equals the number of 16-chunk blocks delivered, from 1 to 4.
- R5: A group that needs a ninth distinct value gives `out_fit` = 0, and `out_dict_cnt`, `out_dict`, `out_idx` and `out_nblk` all read zero.
- R6: A group of more than 64 chunks (more than 4 blocks) gives `out_fit` = 0.
- R7: While `out_valid` is high and `out_ready` is low, the result stays unchanged, `in_ready` is 0 and offered chunks are ignored. After the handshake, the next group starts from an empty dictionary.
- R8: `dec_vld` is high exactly one cycle after a cycle with `dec_req` high. Chunk p of `dec_block` (bits 32p+31..32p) then equals slot `dec_idx[3p+2:3p]` of `dec_dict`.
- R9: A one-block group and an all-zero group both encode and decode correctly. An all-zero group gives one dictionary entry and all indices zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Chunk offered |
| in_ready | output | 1 | Chunk accepted this cycle when valid |
| in_chunk | input | 32 | Chunk value |
| in_last | input | 1 | Final chunk of the group |
| out_valid | output | 1 | Encoded group available |
| out_ready | input | 1 | Consumer takes the encoded group |
| out_fit | output | 1 | Group fits the dictionary |
| out_nblk | output | 3 | Blocks in the group |
| out_dict_cnt | output | 4 | Dictionary entries used |
| out_dict | output | 256 | Dictionary, 8 slots of 32 bits |
| out_idx | output | 192 | 64 indices of 3 bits |
| dec_req | input | 1 | Decode request |
| dec_dict | input | 256 | Dictionary to decode with |
| dec_idx | input | 48 | Index list of one block |
| dec_vld | output | 1 | Decoded block valid |
| dec_block | output | 512 | Decoded block, 16 chunks |

## Verification
The assertions take for granted that the producer keeps `in_valid` and the chunk stable until it is accepted, and that `in_last` is only raised on a chunk that is actually offered. They also expect the consumer to hold `out_ready` steady across each evaluation. The stimulus drives every input half a cycle away from the active edge. It sends whole 16-chunk blocks in order, and it offers chunks during a stalled result only to show that they are ignored. Decode requests use dictionaries and index lists that the encoder produced, plus one hand-made pair.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int CHUNK_W_DEF   = 32;
  localparam int BLK_CHUNK_DEF = 16;
  localparam int GRP_BLK_DEF   = 4;
  localparam int DICT_DEF      = 8;

  typedef enum logic [0:0] {
    ST_COLLECT = 1'b0,
    ST_DONE    = 1'b1
  } enc_state_e;
endpackage

// File: rtl/sdc_dict.sv
module sdc_dict #(
  parameter int CW    = sdc_pkg::CHUNK_W_DEF,
  parameter int DEPTH = sdc_pkg::DICT_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   app,
  input  logic [CW-1:0]          look_data,
  output logic                   hit,
  output logic [$clog2(DEPTH)-1:0] hit_idx,
  output logic                   full,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [DEPTH*CW-1:0]    entries
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CW-1:0]    ent_q [DEPTH];
  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign entries[i*CW +: CW] = ent_q[i];
    assign match[i] = (CNT_W'(i) < count) && (ent_q[i] == look_data);
  end

  assign hit  = |match;
  assign full = (count == CNT_W'(DEPTH));

  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (app && !full) begin
      ent_q[count[IDX_W-1:0]] <= look_data;
      count <= count + 1'b1;
    end
  end

  // R2: the dictionary grows by at most one entry per cycle, or empties
  a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ((count == $past(count) + 1'b1) || (count == '0)));
endmodule

// File: rtl/sdc_encoder.sv
module sdc_encoder #(
  parameter int CW    = sdc_pkg::CHUNK_W_DEF,
  parameter int CPB   = sdc_pkg::BLK_CHUNK_DEF,
  parameter int MAXB  = sdc_pkg::GRP_BLK_DEF,
  parameter int DEPTH = sdc_pkg::DICT_DEF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [CW-1:0]                 in_chunk,
  input  logic                          in_last,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic                          misfit,
  output logic [$clog2(MAXB+1)-1:0]     nblk,
  output logic [$clog2(DEPTH+1)-1:0]    dict_cnt,
  output logic [DEPTH*CW-1:0]           dict_flat,
  output logic [CPB*MAXB*$clog2(DEPTH)-1:0] idx_flat
);
  import sdc_pkg::*;
  localparam int MAX_CH = CPB*MAXB;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CC_W   = $clog2(MAX_CH+1);
  localparam int BC_W   = $clog2(MAXB+1);

  enc_state_e       st;
  logic [CC_W-1:0]  cnt;
  logic [IDX_W-1:0] idx_q [MAX_CH];
  logic             acc, done_hs, too_many, hit, full, app;
  logic [IDX_W-1:0] hit_idx, wr_idx;
  logic [CC_W-1:0]  cnt_inc;
  logic [BC_W-1:0]  blk_seen;

  assign in_ready  = (st == ST_COLLECT);
  assign out_valid = (st == ST_DONE);
  assign acc       = in_valid && in_ready;
  assign done_hs   = out_valid && out_ready;
  assign too_many  = (cnt >= CC_W'(MAX_CH));
  assign app       = acc && !hit && !too_many && !misfit;
  assign wr_idx    = hit ? hit_idx : dict_cnt[IDX_W-1:0];
  assign cnt_inc   = too_many ? cnt : cnt + 1'b1;

  always_comb begin
    int seen;
    seen     = (int'(cnt_inc) + CPB - 1) / CPB;
    blk_seen = BC_W'(seen);
  end

  sdc_dict #(.CW(CW), .DEPTH(DEPTH)) i_dict (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (done_hs),
    .app       (app),
    .look_data (in_chunk),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .full      (full),
    .count     (dict_cnt),
    .entries   (dict_flat)
  );

  for (genvar c = 0; c < MAX_CH; c++) begin : g_idx
    assign idx_flat[c*IDX_W +: IDX_W] = idx_q[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || done_hs) begin
      st     <= ST_COLLECT;
      cnt    <= '0;
      misfit <= 1'b0;
      nblk   <= '0;
      for (int c = 0; c < MAX_CH; c++) idx_q[c] <= '0;
    end else if (acc) begin
      if (!too_many) idx_q[cnt[CC_W-2:0]] <= wr_idx;
      cnt <= cnt_inc;
      if (too_many || (!hit && full)) misfit <= 1'b1;
      if (in_last) begin
        st   <= ST_DONE;
        nblk <= blk_seen;
      end
    end
  end

  // R7: a stalled result keeps its fields
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dict_cnt) && $stable(nblk) && $stable(misfit)));
  // R6: the chunk position never runs past the group capacity
  a_r6_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CC_W'(MAX_CH));
  // R3: a dictionary hit always points at a filled slot
  a_r3_hit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hit) |-> ({1'b0, hit_idx} < dict_cnt));
endmodule

// File: rtl/sdc_decoder.sv
module sdc_decoder #(
  parameter int CW    = sdc_pkg::CHUNK_W_DEF,
  parameter int CPB   = sdc_pkg::BLK_CHUNK_DEF,
  parameter int DEPTH = sdc_pkg::DICT_DEF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dec_req,
  input  logic [DEPTH*CW-1:0]           dec_dict,
  input  logic [CPB*$clog2(DEPTH)-1:0]  dec_idx,
  output logic                          dec_vld,
  output logic [CPB*CW-1:0]             dec_block
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [CW-1:0] slot [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    assign slot[s] = dec_dict[s*CW +: CW];
  end

  for (genvar p = 0; p < CPB; p++) begin : g_chunk
    logic [IDX_W-1:0] sel;
    assign sel = dec_idx[p*IDX_W +: IDX_W];
    always_ff @(posedge clk) begin
      if (!rst_n) dec_block[p*CW +: CW] <= '0;
      else if (dec_req) dec_block[p*CW +: CW] <= slot[sel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dec_vld <= 1'b0;
    else        dec_vld <= dec_req;
  end

  // R8: result one cycle after the request
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    dec_req |=> dec_vld);
  // R8: the decoded block only changes on a request
  a_r8_hold_block: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_req |=> $stable(dec_block));
endmodule

// File: rtl/sdc_compressor.sv
module sdc_compressor #(
  parameter int CW    = sdc_pkg::CHUNK_W_DEF,
  parameter int CPB   = sdc_pkg::BLK_CHUNK_DEF,
  parameter int MAXB  = sdc_pkg::GRP_BLK_DEF,
  parameter int DEPTH = sdc_pkg::DICT_DEF
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [CW-1:0]                     in_chunk,
  input  logic                              in_last,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic                              out_fit,
  output logic [$clog2(MAXB+1)-1:0]         out_nblk,
  output logic [$clog2(DEPTH+1)-1:0]        out_dict_cnt,
  output logic [DEPTH*CW-1:0]               out_dict,
  output logic [CPB*MAXB*$clog2(DEPTH)-1:0] out_idx,
  input  logic                              dec_req,
  input  logic [DEPTH*CW-1:0]               dec_dict,
  input  logic [CPB*$clog2(DEPTH)-1:0]      dec_idx,
  output logic                              dec_vld,
  output logic [CPB*CW-1:0]                 dec_block
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int BC_W  = $clog2(MAXB+1);
  localparam int DC_W  = $clog2(DEPTH+1);

  logic                          misfit;
  logic [BC_W-1:0]               nblk;
  logic [DC_W-1:0]               dict_cnt;
  logic [DEPTH*CW-1:0]           dict_flat;
  logic [CPB*MAXB*IDX_W-1:0]     idx_flat;

  sdc_encoder #(.CW(CW), .CPB(CPB), .MAXB(MAXB), .DEPTH(DEPTH)) i_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_chunk  (in_chunk),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .misfit    (misfit),
    .nblk      (nblk),
    .dict_cnt  (dict_cnt),
    .dict_flat (dict_flat),
    .idx_flat  (idx_flat)
  );

  assign out_fit      = !misfit;
  assign out_nblk     = misfit ? '0 : nblk;
  assign out_dict_cnt = misfit ? '0 : dict_cnt;
  assign out_dict     = misfit ? '0 : dict_flat;
  assign out_idx      = misfit ? '0 : idx_flat;

  sdc_decoder #(.CW(CW), .CPB(CPB), .DEPTH(DEPTH)) i_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_req   (dec_req),
    .dec_dict  (dec_dict),
    .dec_idx   (dec_idx),
    .dec_vld   (dec_vld),
    .dec_block (dec_block)
  );

  // R4: a fitting group reports between one and the maximum number of blocks
  a_r4_nblk_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fit) |-> ((out_nblk >= BC_W'(1)) && (out_nblk <= BC_W'(MAXB))));
endmodule

// File: tb/test_sdc_compressor.sv
module test_sdc_compressor;
  localparam int NROW = 10;
  // row: {nblk[13:11], kind[10:9], k[8:5], exp_fit[4], exp_cnt[3:0]}
  localparam logic [13:0] ROWS [NROW] = '{
    {3'd1, 2'd0, 4'd0, 1'b1, 4'd1},
    {3'd4, 2'd0, 4'd0, 1'b1, 4'd1},
    {3'd1, 2'd1, 4'd8, 1'b1, 4'd8},
    {3'd4, 2'd1, 4'd5, 1'b1, 4'd5},
    {3'd2, 2'd1, 4'd9, 1'b0, 4'd0},
    {3'd3, 2'd2, 4'd0, 1'b0, 4'd0},
    {3'd4, 2'd1, 4'd3, 1'b1, 4'd3},
    {3'd2, 2'd3, 4'd0, 1'b1, 4'd4},
    {3'd5, 2'd0, 4'd0, 1'b0, 4'd0},
    {3'd4, 2'd1, 4'd8, 1'b1, 4'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1, dec_req = 1'b0;
  logic [31:0]  in_chunk = '0;
  logic [255:0] dec_dict = '0;
  logic [47:0]  dec_idx = '0;
  logic         in_ready, out_valid, out_fit, dec_vld;
  logic [2:0]   out_nblk;
  logic [3:0]   out_dict_cnt;
  logic [255:0] out_dict;
  logic [191:0] out_idx;
  logic [511:0] dec_block;

  int n_chk = 0, n_fail = 0;
  logic [31:0]  g [80];
  logic [255:0] cap_dict, m_dict;
  logic [191:0] cap_idx, m_idx;
  logic [3:0]   cap_cnt, m_cnt;
  logic [2:0]   cap_nblk;
  logic         cap_fit, m_fit;

  always #10 clk = ~clk;

  sdc_compressor i_sdc_compressor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chunk(in_chunk), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_fit(out_fit), .out_nblk(out_nblk),
    .out_dict_cnt(out_dict_cnt), .out_dict(out_dict), .out_idx(out_idx),
    .dec_req(dec_req), .dec_dict(dec_dict), .dec_idx(dec_idx),
    .dec_vld(dec_vld), .dec_block(dec_block)
  );

  task automatic check(input logic ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(input int kind, input int k, input int row, input int blk, input int pos);
    logic [31:0] x;
    int i;
    i = blk*16 + pos;
    case (kind)
      0: x = 32'h0;
      1: x = 32'hC0DE_0000 + 32'(row*256) + 32'(i % k);
      2: begin
        x = 32'(i + 1 + row*1000) * 32'h9E37_79B1;
        x = x ^ (x >> 15);
      end
      default: x = 32'h5A5A_0000 ^ 32'(blk*2 + (pos & 1));
    endcase
    return x;
  endfunction

  task automatic build_model(input int n);
    logic [31:0] md [8];
    int found;
    m_cnt = 0; m_fit = (n <= 64); m_idx = '0;
    for (int s = 0; s < 8; s++) md[s] = '0;
    for (int c = 0; c < n && c < 64; c++) begin
      found = -1;
      for (int s = 0; s < 8; s++) if (s < int'(m_cnt) && md[s] == g[c] && found < 0) found = s;
      if (found < 0) begin
        if (m_cnt < 8) begin md[m_cnt[2:0]] = g[c]; found = int'(m_cnt); m_cnt = m_cnt + 1; end
        else m_fit = 1'b0;
      end
      if (found >= 0) m_idx[c*3 +: 3] = 3'(found);
    end
    for (int s = 0; s < 8; s++) m_dict[s*32 +: 32] = md[s];
  endtask

  task automatic send_group(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      in_valid = 1'b1; in_chunk = g[c]; in_last = (c == n-1);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    cap_fit = out_fit; cap_nblk = out_nblk; cap_cnt = out_dict_cnt;
    cap_dict = out_dict; cap_idx = out_idx;
    check(out_valid, "R7", 512'(out_valid), 512'(1));
  endtask

  task automatic decode(input logic [255:0] d, input logic [47:0] ix, output logic [511:0] res, output logic v);
    @(negedge clk);
    dec_req = 1'b1; dec_dict = d; dec_idx = ix;
    @(negedge clk);
    dec_req = 1'b0;
    res = dec_block; v = dec_vld;
  endtask

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [511:0] res, exp_blk;
    logic v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(in_ready && !out_valid && !dec_vld, "R1", {in_ready, out_valid, dec_vld}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid, "R1", {in_ready, out_valid}, 2'b10);

    for (int r = 0; r < NROW; r++) begin
      int nb, kind, k, n;
      nb = int'(ROWS[r][13:11]); kind = int'(ROWS[r][10:9]); k = int'(ROWS[r][8:5]);
      n = nb*16;
      for (int b = 0; b < nb; b++)
        for (int p = 0; p < 16; p++) g[b*16+p] = gen(kind, k, r, b, p);
      build_model(n);
      send_group(n);
      check(cap_fit == ROWS[r][4], (nb > 4) ? "R6" : "R5", 512'(cap_fit), 512'(ROWS[r][4]));
      check(m_fit == ROWS[r][4], "R5", 512'(m_fit), 512'(ROWS[r][4]));
      if (ROWS[r][4]) begin
        check(cap_cnt == ROWS[r][3:0], "R2", 512'(cap_cnt), 512'(ROWS[r][3:0]));
        check(cap_dict == m_dict, "R2", 512'(cap_dict), 512'(m_dict));
        check(cap_idx == m_idx, "R3", 512'(cap_idx), 512'(m_idx));
        check(cap_nblk == 3'(nb), "R4", 512'(cap_nblk), 512'(nb));
        if (kind == 0) check(cap_idx == '0 && cap_cnt == 4'd1, "R9", 512'(cap_idx), 512'(0));
        for (int b = 0; b < nb; b++) begin
          for (int p = 0; p < 16; p++) exp_blk[p*32 +: 32] = g[b*16+p];
          decode(cap_dict, cap_idx[b*48 +: 48], res, v);
          check(v && res == exp_blk, (nb == 1) ? "R9" : "R8", res, exp_blk);
        end
      end else begin
        check(cap_cnt == '0 && cap_dict == '0 && cap_idx == '0 && cap_nblk == '0, "R5",
              {cap_cnt, cap_nblk, cap_dict[31:0]}, 512'(0));
      end
    end

    // R7: back-pressure, stall and ignore chunks offered meanwhile
    out_ready = 1'b0;
    for (int p = 0; p < 16; p++) g[p] = 32'h1000 + 32'(p % 2);
    send_group(16);
    @(negedge clk);
    in_valid = 1'b1; in_chunk = 32'hDEAD_BEEF; in_last = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid && !in_ready, "R7", {out_valid, in_ready}, 2'b10);
    check(out_dict == cap_dict && out_dict_cnt == 4'd2 && out_idx == cap_idx, "R7",
          512'(out_dict), 512'(cap_dict));
    in_valid = 1'b0; in_last = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R7", {out_valid, in_ready}, 2'b01);
    for (int p = 0; p < 16; p++) g[p] = 32'h0;
    send_group(16);
    check(cap_cnt == 4'd1 && cap_dict == '0, "R7", 512'(cap_dict), 512'(0));

    // R8: hand-made dictionary, reversed index pattern, then idle
    begin
      logic [255:0] d;
      logic [47:0] ix;
      for (int s = 0; s < 8; s++) d[s*32 +: 32] = 32'hAB00_0000 + 32'(s * 17);
      for (int p = 0; p < 16; p++) begin
        ix[p*3 +: 3] = 3'(7 - (p % 8));
        exp_blk[p*32 +: 32] = 32'hAB00_0000 + 32'((7 - (p % 8)) * 17);
      end
      decode(d, ix, res, v);
      check(v && res == exp_blk, "R8", res, exp_blk);
      @(negedge clk);
      check(!dec_vld && dec_block == exp_blk, "R8", 512'(dec_vld), 512'(0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule